// File: doc/BRIEF.md
# Limited-Range Output Clamp

This block sits at the end of a pixel pipeline. It limits each of the three 12-bit colour components of a streaming pixel to a legal range. A 3-bit format code chooses the range, and a single enable bit turns clamping on when the sink asks for limited-range video. With the enable clear, pixels pass through untouched.

The fixed limited-range formats use the video limits 16 and 235. These are scaled to 8, 10 or 12 bits per channel and left-aligned in the 12-bit word. Because the values are left-aligned, all three depths give the same bounds, 0x100 and 0xEB0. The programmable format applies a separate lower and upper bound to each of R, G and B. Firmware normally loads these bounds with 0x010 and 0xFEF. The result is registered, and the valid flag travels with the data.

Top module: `pix_clamp`

## Requirements
- R1: The pixel word carries R in bits [35:24], G in [23:12] and B in [11:0]. The result appears on `pix_o` one clock after it is presented with `valid_i` high, and `valid_o` equals `valid_i` delayed by one clock.
- R2: While `rst_ni` is low, `valid_o` is 0 and `pix_o` is 0.
- R3: When `enable_i` is 0, each output component equals its input for every value of `fmt_i`.
- R4: Format code 0 (6 bits per channel) leaves the data unclamped even with `enable_i` high.
- R5: With `enable_i` high, format codes 1, 2 and 3 (8, 10 and 12 bits per channel) clamp every component to 0x100..0xEB0.
- R6: With `enable_i` high, format code 7 clamps R, G and B each to its own bound pair, independently of the other components. The defaults 0x010 and 0xFEF are one valid setting of these bounds.
- R7: Format codes 4, 5 and 6 pass the data unclamped.
- R8: When clamping is active, both bounds are inclusive. A value below the lower bound becomes the lower bound, a value above the upper bound becomes the upper bound, and any other value is unchanged.
- R9: When a programmable lower bound exceeds its upper bound, the lower test takes priority. A value below the lower bound yields the lower bound, and any other value yields the upper bound.
- R10: A cycle with `valid_i` low leaves `pix_o` unchanged and drives `valid_o` low on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input pixel qualifier |
| pix_i | input | 36 | Input pixel {R,G,B} |
| enable_i | input | 1 | Limited-range clamp enable |
| fmt_i | input | 3 | Range format code |
| lo_r_i | input | 12 | Programmable lower bound, R |
| hi_r_i | input | 12 | Programmable upper bound, R |
| lo_g_i | input | 12 | Programmable lower bound, G |
| hi_g_i | input | 12 | Programmable upper bound, G |
| lo_b_i | input | 12 | Programmable lower bound, B |
| hi_b_i | input | 12 | Programmable upper bound, B |
| valid_o | output | 1 | Output pixel qualifier |
| pix_o | output | 36 | Clamped pixel {R,G,B} |

## Verification
The hardest cases to reach are the exact bound edges for all three components within a single setting. Inverted programmable bounds are also hard to reach, because a legal stream never produces them. The stimulus sweeps every 12-bit code through R while G and B carry a mirrored ramp and a scrambled ramp. Each component therefore crosses both of its bounds in the same sweep. The sweep repeats for every format code, with the enable both set and clear. It then runs twice more: once with distinct per-component bounds, and once with an inverted bound pair.

// File: rtl/pix_clamp_pkg.sv
package pix_clamp_pkg;
  localparam logic [2:0] FMT_NONE  = 3'd0;
  localparam logic [2:0] FMT_LIM8  = 3'd1;
  localparam logic [2:0] FMT_LIM10 = 3'd2;
  localparam logic [2:0] FMT_LIM12 = 3'd3;
  localparam logic [2:0] FMT_PROG  = 3'd7;

  localparam int unsigned VID_LO = 16;
  localparam int unsigned VID_HI = 235;

  // video level scaled to depth, then left-aligned into a w-bit word
  function automatic int unsigned lim_level(int unsigned lvl, int unsigned depth,
                                            int unsigned w);
    int unsigned t;
    t = lvl << (depth - 8);
    return t << (w - depth);
  endfunction
endpackage

// File: rtl/pix_clamp_range.sv
module pix_clamp_range
  import pix_clamp_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         enable_i,
  input  logic [2:0]   fmt_i,
  input  logic [W-1:0] plo_i,
  input  logic [W-1:0] phi_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o,
  output logic         act_o
);
  localparam logic [W-1:0] LO8  = W'(lim_level(VID_LO, 8,  W));
  localparam logic [W-1:0] HI8  = W'(lim_level(VID_HI, 8,  W));
  localparam logic [W-1:0] LO10 = W'(lim_level(VID_LO, 10, W));
  localparam logic [W-1:0] HI10 = W'(lim_level(VID_HI, 10, W));
  localparam logic [W-1:0] LO12 = W'(lim_level(VID_LO, 12, W));
  localparam logic [W-1:0] HI12 = W'(lim_level(VID_HI, 12, W));

  always_comb begin
    act_o = 1'b0;
    lo_o  = '0;
    hi_o  = '1;
    if (enable_i) begin
      unique case (fmt_i)
        FMT_LIM8:  begin act_o = 1'b1; lo_o = LO8;   hi_o = HI8;   end
        FMT_LIM10: begin act_o = 1'b1; lo_o = LO10;  hi_o = HI10;  end
        FMT_LIM12: begin act_o = 1'b1; lo_o = LO12;  hi_o = HI12;  end
        FMT_PROG:  begin act_o = 1'b1; lo_o = plo_i; hi_o = phi_i; end
        default:   act_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pix_clamp_lane.sv
module pix_clamp_lane #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] v_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  input  logic         act_i,
  output logic [W-1:0] v_o
);
  // lower test wins when bounds are inverted
  always_comb begin
    if (!act_i)          v_o = v_i;
    else if (v_i < lo_i) v_o = lo_i;
    else if (v_i > hi_i) v_o = hi_i;
    else                 v_o = v_i;
  end
endmodule

// File: rtl/pix_clamp.sv
module pix_clamp
  import pix_clamp_pkg::*;
#(
  parameter int unsigned W = 12,
  localparam int unsigned NC = 3,
  localparam int unsigned PW = NC * W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [PW-1:0] pix_i,
  input  logic          enable_i,
  input  logic [2:0]    fmt_i,
  input  logic [W-1:0]  lo_r_i,
  input  logic [W-1:0]  hi_r_i,
  input  logic [W-1:0]  lo_g_i,
  input  logic [W-1:0]  hi_g_i,
  input  logic [W-1:0]  lo_b_i,
  input  logic [W-1:0]  hi_b_i,
  output logic          valid_o,
  output logic [PW-1:0] pix_o
);
  logic [W-1:0] plo [NC];
  logic [W-1:0] phi [NC];
  logic [PW-1:0] pix_d;

  // index 2 = R (top), 0 = B (bottom)
  assign plo[2] = lo_r_i;
  assign phi[2] = hi_r_i;
  assign plo[1] = lo_g_i;
  assign phi[1] = hi_g_i;
  assign plo[0] = lo_b_i;
  assign phi[0] = hi_b_i;

  for (genvar c = 0; c < NC; c++) begin : g_comp
    logic [W-1:0] lo, hi;
    logic         act;
    pix_clamp_range #(.W(W)) u_rng (
      .enable_i(enable_i), .fmt_i(fmt_i), .plo_i(plo[c]), .phi_i(phi[c]),
      .lo_o(lo), .hi_o(hi), .act_o(act)
    );
    pix_clamp_lane #(.W(W)) u_lane (
      .v_i(pix_i[c*W +: W]), .lo_i(lo), .hi_i(hi), .act_i(act),
      .v_o(pix_d[c*W +: W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pix_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) pix_o <= pix_d;
    end
  end

  // R1
  valid_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(pix_o)));
  // R3
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !enable_i) |=> (pix_o == $past(pix_i)));
  // R5
  fixed_rng_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && enable_i && fmt_i == FMT_LIM8) |=>
      (pix_o[PW-1 -: W] >= W'(lim_level(VID_LO, 8, W)) &&
       pix_o[PW-1 -: W] <= W'(lim_level(VID_HI, 8, W))));
  // R6
  prog_rng_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && enable_i && fmt_i == FMT_PROG && lo_g_i <= hi_g_i) |=>
      (pix_o[W +: W] >= $past(lo_g_i) && pix_o[W +: W] <= $past(hi_g_i)));
endmodule

// File: tb/sim_pix_clamp.sv
module sim_pix_clamp;
  localparam int W = 12;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [35:0] pix = '0;
  logic en = 1'b0;
  logic [2:0] fmt = '0;
  logic [11:0] lor = 12'h010, hir = 12'hFEF, log_ = 12'h010, hig = 12'hFEF;
  logic [11:0] lob = 12'h010, hib = 12'hFEF;
  logic valid_o;
  logic [35:0] pix_o;
  int errors = 0, checks = 0;
  logic [35:0] prev_exp = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pix_clamp u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .pix_i(pix),
    .enable_i(en), .fmt_i(fmt),
    .lo_r_i(lor), .hi_r_i(hir), .lo_g_i(log_), .hi_g_i(hig),
    .lo_b_i(lob), .hi_b_i(hib), .valid_o(valid_o), .pix_o(pix_o)
  );

  function automatic logic [11:0] mdl(logic [11:0] v, logic e, logic [2:0] f,
                                      logic [11:0] pl, logic [11:0] ph);
    int lo, hi, d;
    if (!e) return v;
    if (f >= 3'd1 && f <= 3'd3) begin
      d  = 6 + 2 * int'(f);
      lo = (16 << (d - 8)) << (12 - d);
      hi = (235 << (d - 8)) << (12 - d);
    end else if (f == 3'd7) begin
      lo = int'(pl);
      hi = int'(ph);
    end else return v;
    if (int'(v) < lo) return 12'(lo);
    if (int'(v) > hi) return 12'(hi);
    return v;
  endfunction

  function automatic string tag_of(logic e, logic [2:0] f);
    if (!e) return "R3";
    if (f == 3'd0) return "R4";
    if (f <= 3'd3) return "R5/R8";
    if (f == 3'd7) return "R6/R8";
    return "R7";
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one pixel, then check result after the next rising edge
  task automatic apply(logic v, logic [35:0] p, string req);
    logic [35:0] exp;
    @(negedge clk);
    valid = v;
    pix = p;
    if (v) exp = {mdl(p[35:24], en, fmt, lor, hir), mdl(p[23:12], en, fmt, log_, hig),
                  mdl(p[11:0], en, fmt, lob, hib)};
    else exp = prev_exp;
    @(posedge clk);
    #1;
    chk(req, 64'(pix_o), 64'(exp));
    chk("R1 valid", 64'(valid_o), 64'(v));
    prev_exp = exp;
  endtask

  task automatic sweep(string req);
    for (int i = 0; i < 4096; i++) begin
      logic [11:0] r, g, b;
      r = 12'(i);
      g = 12'(4095 - i);
      b = 12'((i * 37 + 5) & 12'hFFF);
      apply(1'b1, {r, g, b}, req);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R2 reset valid", 64'(valid_o), 64'(0));
    chk("R2 reset pix", 64'(pix_o), 64'(0));
    @(negedge clk);
    rst_n = 1'b1;
    // main sweep: every format, enable clear and set; fmt 7 with default bounds
    for (int e = 0; e < 2; e++) begin
      for (int f = 0; f < 8; f++) begin
        @(negedge clk);
        en = 1'(e);
        fmt = 3'(f);
        sweep(tag_of(en, fmt));
      end
    end
    // R6 distinct per-component bounds
    @(negedge clk);
    en = 1'b1; fmt = 3'd7;
    lor = 12'h200; hir = 12'h900;
    log_ = 12'h040; hig = 12'hC00;
    lob = 12'h7FF; hib = 12'h800;
    sweep("R6 per-component");
    // R8 exact bound edges on R
    apply(1'b1, {12'h1FF, 12'h03F, 12'h7FE}, "R8 below");
    apply(1'b1, {12'h200, 12'h040, 12'h7FF}, "R8 at lower");
    apply(1'b1, {12'h900, 12'hC00, 12'h800}, "R8 at upper");
    apply(1'b1, {12'h901, 12'hC01, 12'h801}, "R8 above");
    // R9 inverted bounds
    lor = 12'hA00; hir = 12'h300;
    sweep("R9 inverted");
    apply(1'b1, {12'h9FF, 12'h000, 12'h000}, "R9 below lo");
    chk("R9 yields lo", 64'(pix_o[35:24]), 64'(12'hA00));
    apply(1'b1, {12'hA00, 12'h000, 12'h000}, "R9 at lo");
    chk("R9 yields hi", 64'(pix_o[35:24]), 64'(12'h300));
    // R10 hold with changing inputs
    apply(1'b1, 36'h123456789, "R10 load");
    apply(1'b0, 36'hFFFFFFFFF, "R10 hold");
    apply(1'b0, 36'h000000000, "R10 hold");
    apply(1'b1, 36'h000FFF000, "R10 resume");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule